// File: doc/BRIEF.md
# Memory map access checker

This block sits on the request path of a 32-bit system bus, in front of the slaves. In every address phase it sorts the address into one of the architectural regions of the 4 GB space. For that region it returns the memory kind, the execute-never flag, the cache policy and the shareability. In the same cycle it decides whether the transfer may go on to a slave.

The following transfers are refused:
- an instruction fetch into an execute-never region;
- a misaligned transfer;
- an unprivileged touch of the system control page;
- an access to the reserved top of the map;
- an access to an address with no populated slave window.

For a refused transfer the block answers with the standard two-cycle bus ERROR response and keeps the slave select low. For a legal transfer it raises the slave select and passes the slave's ready and response through during the data phase.

The populated windows are parameters. Each window is a base address and a power-of-two size. The private peripheral bus range is always treated as populated.

Top module: `mmap_guard`

## Requirements
- R1: Attribute outputs follow the address in the address phase. kind codes are 0 normal, 1 device, 2 strongly ordered, 3 none; cache codes are 0 none, 1 write-through, 2 write-back write-allocate. The regions are:
  - 0x00000000–0x1FFFFFFF: normal, write-through.
  - 0x20000000–0x3FFFFFFF: normal, write-back write-allocate.
  - 0x60000000–0x7FFFFFFF: normal, write-back write-allocate.
  - 0x80000000–0x9FFFFFFF: normal, write-through.
  - All four of these ranges are executable and not shareable.
- R2: The remaining regions are all execute-never with cache code 0:
  - 0x40000000–0x5FFFFFFF: device, not shareable.
  - 0xA0000000–0xBFFFFFFF: device, shareable.
  - 0xC0000000–0xDFFFFFFF: device, not shareable.
  - 0xE0000000–0xE00FFFFF: strongly ordered, shareable.
  - 0xE0100000–0xFFFFFFFF: kind 3, not shareable.
- R3: A request with the fetch flag set is refused with ERROR if its region is execute-never, or if the write flag is also set. A data access to a populated execute-never address completes normally.
- R4: Transfer size codes are 0 byte, 1 halfword and 2 word. A halfword with address bit 0 set is refused. A word with either of address bits 1:0 set is refused. Any size code above 2 is refused. Bytes are never refused for alignment.
- R5: An unprivileged access to 0xE000E000–0xE000EFFF is refused. A privileged access there is accepted. An unprivileged access elsewhere in 0xE0000000–0xE00FFFFF is accepted.
- R6: Any access to 0xE0100000–0xFFFFFFFF, whether data or fetch, is refused.
- R7: An access outside every populated window is refused. The exception is the range 0xE0000000–0xE00FFFFF, which is always populated.
- R8: A refused transfer gives, in the cycle after its address phase, ready low with response high. In the following cycle it gives ready high with response high.
- R9: Transfer type codes are 0 idle, 1 busy, 2 non-sequential and 3 sequential. Idle and busy never raise the slave select and never produce an error, whatever the address.
- R10: A legal non-sequential or sequential transfer raises the slave select in its address phase. During its data phase the block's ready and response equal the slave's.
- R11: After reset, ready is high, response is low and the slave select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| htrans_i | input | 2 | Transfer type (0 idle, 1 busy, 2 non-sequential, 3 sequential) |
| haddr_i | input | 32 | Transfer address |
| hsize_i | input | 3 | Transfer size (0 byte, 1 halfword, 2 word) |
| fetch_i | input | 1 | High for an instruction fetch |
| priv_i | input | 1 | High for a privileged access |
| write_i | input | 1 | High for a write |
| slv_ready_i | input | 1 | Slave ready during a forwarded data phase |
| slv_resp_i | input | 1 | Slave response during a forwarded data phase |
| hready_o | output | 1 | Ready returned to the master |
| hresp_o | output | 1 | Response returned to the master (1 = ERROR) |
| fwd_sel_o | output | 1 | Transfer accepted and forwarded to the slaves |
| attr_kind_o | output | 2 | Memory kind of the addressed region |
| attr_xn_o | output | 1 | Execute-never flag of the region |
| attr_cache_o | output | 2 | Cache policy of the region |
| attr_shared_o | output | 1 | Shareability of the region |

## Verification
The bench builds the block with five populated windows:
- 64 KB at the bottom of the code region;
- 16 KB of SRAM;
- 4 KB of peripheral space;
- 4 KB at the start of the write-through RAM half;
- 4 KB at the start of the shareable device half.

This puts accepted transfers within reach in code, SRAM, peripheral, upper RAM, shareable device and the private peripheral range. The lower RAM half and the non-shareable device half stay unpopulated, so the same run also reaches the unpopulated-window refusal in regions whose attributes are still checked.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int unsigned AW = 32;
    localparam logic [11:0] PPB_PAGE = 12'hE00;
    localparam logic [19:0] SCS_PAGE = 20'hE000E;

    typedef enum logic [1:0] {
        MK_NORMAL = 2'd0,
        MK_DEVICE = 2'd1,
        MK_STRONG = 2'd2,
        MK_NONE   = 2'd3
    } mem_kind_e;

    typedef enum logic [1:0] {
        CP_NONE = 2'd0,
        CP_WT   = 2'd1,
        CP_WBWA = 2'd2
    } cache_pol_e;

    typedef enum logic [3:0] {
        RG_CODE, RG_SRAM, RG_PERIPH, RG_RAM_WB, RG_RAM_WT,
        RG_DEV_SH, RG_DEV_NSH, RG_PPB, RG_RESV
    } region_e;

    typedef enum logic [1:0] {
        RS_OPEN, RS_FWD, RS_ERR1, RS_ERR2
    } resp_state_e;

    typedef struct packed {
        mem_kind_e  kind;
        logic       xn;
        cache_pol_e cpol;
        logic       shared;
    } region_attr_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [2:0]    size;
        logic          fetch;
        logic          priv;
        logic          write;
    } bus_req_t;

    typedef struct packed {
        logic no_exec;
        logic misalign;
        logic no_priv;
        logic unmapped;
    } fault_t;

    function automatic region_e region_of(input logic [AW-1:0] a);
        region_e r;
        unique case (a[31:29])
            3'd0:    r = RG_CODE;
            3'd1:    r = RG_SRAM;
            3'd2:    r = RG_PERIPH;
            3'd3:    r = RG_RAM_WB;
            3'd4:    r = RG_RAM_WT;
            3'd5:    r = RG_DEV_SH;
            3'd6:    r = RG_DEV_NSH;
            default: r = (a[31:20] == PPB_PAGE) ? RG_PPB : RG_RESV;
        endcase
        return r;
    endfunction

    function automatic region_attr_t attr_of(input region_e r);
        region_attr_t t;
        t = '{kind: MK_NONE, xn: 1'b1, cpol: CP_NONE, shared: 1'b0};
        unique case (r)
            RG_CODE:    t = '{kind: MK_NORMAL, xn: 1'b0, cpol: CP_WT,   shared: 1'b0};
            RG_SRAM:    t = '{kind: MK_NORMAL, xn: 1'b0, cpol: CP_WBWA, shared: 1'b0};
            RG_PERIPH:  t = '{kind: MK_DEVICE, xn: 1'b1, cpol: CP_NONE, shared: 1'b0};
            RG_RAM_WB:  t = '{kind: MK_NORMAL, xn: 1'b0, cpol: CP_WBWA, shared: 1'b0};
            RG_RAM_WT:  t = '{kind: MK_NORMAL, xn: 1'b0, cpol: CP_WT,   shared: 1'b0};
            RG_DEV_SH:  t = '{kind: MK_DEVICE, xn: 1'b1, cpol: CP_NONE, shared: 1'b1};
            RG_DEV_NSH: t = '{kind: MK_DEVICE, xn: 1'b1, cpol: CP_NONE, shared: 1'b0};
            RG_PPB:     t = '{kind: MK_STRONG, xn: 1'b1, cpol: CP_NONE, shared: 1'b1};
            default:    t = '{kind: MK_NONE,   xn: 1'b1, cpol: CP_NONE, shared: 1'b0};
        endcase
        return t;
    endfunction

    function automatic logic misaligned(input logic [1:0] lsb, input logic [2:0] size);
        logic m;
        unique case (size)
            3'd0:    m = 1'b0;
            3'd1:    m = lsb[0];
            3'd2:    m = |lsb;
            default: m = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
    import mmap_pkg::*;
(
    input  logic [AW-1:0] addr,
    output region_e       region,
    output region_attr_t  attr
);
    always_comb begin
        region = region_of(addr);
        attr   = attr_of(region);
    end
endmodule

// File: rtl/mmap_window_match.sv
module mmap_window_match
    import mmap_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter logic [NUM_WIN-1:0][31:0] WIN_BASE = '0,
    parameter logic [NUM_WIN-1:0][5:0]  WIN_LOG2 = '0
)(
    input  logic [AW-1:0] addr,
    output logic          any_hit
);
    logic [NUM_WIN-1:0] hit;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [31:0] SPAN = (32'h1 << WIN_LOG2[i]) - 32'h1;
        localparam logic [31:0] KEEP = ~SPAN;
        assign hit[i] = ((addr ^ WIN_BASE[i]) & KEEP) == 32'h0;
    end

    assign any_hit = |hit;
endmodule

// File: rtl/mmap_rule_eval.sv
module mmap_rule_eval
    import mmap_pkg::*;
(
    input  bus_req_t     req,
    input  region_e      region,
    input  region_attr_t attr,
    input  logic         win_hit,
    output fault_t       fault,
    output logic         illegal
);
    always_comb begin
        fault.no_exec  = req.fetch & (attr.xn | req.write);
        fault.misalign = misaligned(req.addr[1:0], req.size);
        fault.no_priv  = ~req.priv & (req.addr[31:12] == SCS_PAGE);
        fault.unmapped = (region == RG_RESV) | ((region != RG_PPB) & ~win_hit);
        illegal        = |fault;
    end
endmodule

// File: rtl/mmap_resp_fsm.sv
module mmap_resp_fsm
    import mmap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic illegal,
    input  logic slv_ready,
    input  logic slv_resp,
    output logic ready,
    output logic resp,
    output logic accept
);
    resp_state_e st_q, st_d;

    always_comb begin
        unique case (st_q)
            RS_OPEN: begin ready = 1'b1;      resp = 1'b0;     end
            RS_FWD:  begin ready = slv_ready; resp = slv_resp; end
            RS_ERR1: begin ready = 1'b0;      resp = 1'b1;     end
            default: begin ready = 1'b1;      resp = 1'b1;     end
        endcase
        accept = ready & active;
    end

    always_comb begin
        st_d = st_q;
        if (st_q == RS_ERR1)
            st_d = RS_ERR2;
        else if (ready)
            st_d = accept ? (illegal ? RS_ERR1 : RS_FWD) : RS_OPEN;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RS_OPEN;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/mmap_guard.sv
module mmap_guard
    import mmap_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter logic [NUM_WIN-1:0][31:0] WIN_BASE =
        {32'hA000_0000, 32'h4000_0000, 32'h2000_0000, 32'h0000_0000},
    parameter logic [NUM_WIN-1:0][5:0]  WIN_LOG2 =
        {6'd12, 6'd16, 6'd15, 6'd17}
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  htrans_i,
    input  logic [31:0] haddr_i,
    input  logic [2:0]  hsize_i,
    input  logic        fetch_i,
    input  logic        priv_i,
    input  logic        write_i,
    input  logic        slv_ready_i,
    input  logic        slv_resp_i,
    output logic        hready_o,
    output logic        hresp_o,
    output logic        fwd_sel_o,
    output logic [1:0]  attr_kind_o,
    output logic        attr_xn_o,
    output logic [1:0]  attr_cache_o,
    output logic        attr_shared_o
);
    bus_req_t     req;
    region_e      region;
    region_attr_t attr;
    fault_t       fault;
    logic         win_hit, illegal, active, accept;

    assign req    = '{addr: haddr_i, size: hsize_i, fetch: fetch_i,
                      priv: priv_i, write: write_i};
    assign active = htrans_i[1];

    mmap_region_decode u_dec (
        .addr   (haddr_i),
        .region (region),
        .attr   (attr)
    );

    mmap_window_match #(
        .NUM_WIN  (NUM_WIN),
        .WIN_BASE (WIN_BASE),
        .WIN_LOG2 (WIN_LOG2)
    ) u_win (
        .addr    (haddr_i),
        .any_hit (win_hit)
    );

    mmap_rule_eval u_rule (
        .req     (req),
        .region  (region),
        .attr    (attr),
        .win_hit (win_hit),
        .fault   (fault),
        .illegal (illegal)
    );

    mmap_resp_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .illegal   (illegal),
        .slv_ready (slv_ready_i),
        .slv_resp  (slv_resp_i),
        .ready     (hready_o),
        .resp      (hresp_o),
        .accept    (accept)
    );

    assign fwd_sel_o     = accept & ~illegal;
    assign attr_kind_o   = attr.kind;
    assign attr_xn_o     = attr.xn;
    assign attr_cache_o  = attr.cpol;
    assign attr_shared_o = attr.shared;
endmodule

// File: rtl/mmap_guard_chk.sv
module mmap_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  htrans_i,
    input logic [31:0] haddr_i,
    input logic [2:0]  hsize_i,
    input logic        fetch_i,
    input logic        priv_i,
    input logic        write_i,
    input logic        hready_o,
    input logic        hresp_o,
    input logic        fwd_sel_o,
    input logic [1:0]  attr_kind_o,
    input logic        attr_xn_o,
    input logic [1:0]  attr_cache_o,
    input logic        attr_shared_o
);
    logic take;
    assign take = hready_o & htrans_i[1];

    AST_ERR_SECOND: assert property (@(posedge clk) disable iff (rst)
        (!hready_o && hresp_o) |=> (hready_o && hresp_o)); // R8
    AST_FETCH_XN: assert property (@(posedge clk) disable iff (rst)
        (take && fetch_i && (attr_xn_o || write_i)) |=> (hresp_o && !hready_o)); // R3
    AST_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (take && hsize_i == 3'd2 && haddr_i[1:0] != 2'b00) |=> (hresp_o && !hready_o)); // R4
    AST_SCS_PRIV: assert property (@(posedge clk) disable iff (rst)
        (take && !priv_i && haddr_i[31:12] == 20'hE000E) |=> (hresp_o && !hready_o)); // R5
    AST_RESV_ERR: assert property (@(posedge clk) disable iff (rst)
        (take && haddr_i[31:20] > 12'hE00) |=> (hresp_o && !hready_o)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (hready_o && !htrans_i[1]) |=> !hresp_o); // R9
    AST_SEL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        fwd_sel_o |-> (hready_o && htrans_i[1])); // R10

    always_comb begin
        if (!rst) begin
            AST_WT_HALF: assert (haddr_i[31:29] != 3'd4 || attr_cache_o == 2'd1); // R1
            AST_PPB_ATTR: assert (haddr_i[31:20] != 12'hE00
                || (attr_kind_o == 2'd2 && attr_shared_o && attr_xn_o)); // R2
        end
    end
endmodule

bind mmap_guard mmap_guard_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .htrans_i      (htrans_i),
    .haddr_i       (haddr_i),
    .hsize_i       (hsize_i),
    .fetch_i       (fetch_i),
    .priv_i        (priv_i),
    .write_i       (write_i),
    .hready_o      (hready_o),
    .hresp_o       (hresp_o),
    .fwd_sel_o     (fwd_sel_o),
    .attr_kind_o   (attr_kind_o),
    .attr_xn_o     (attr_xn_o),
    .attr_cache_o  (attr_cache_o),
    .attr_shared_o (attr_shared_o)
);

// File: tb/mmap_guard_bench.sv
`timescale 1ns/1ps
module mmap_guard_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  htrans = 2'd0;
    logic [31:0] haddr = 32'h0;
    logic [2:0]  hsize = 3'd0;
    logic        fetch = 1'b0, priv = 1'b1, write = 1'b0;
    logic        slv_ready = 1'b1, slv_resp = 1'b0;
    logic        hready, hresp, fwd_sel, a_xn, a_sh;
    logic [1:0]  a_kind, a_cache;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic  err;
        string tag;
    } exp_t;
    exp_t q[$];
    event ph_ev;

    always #4 clk = ~clk;

    mmap_guard #(
        .NUM_WIN  (5),
        .WIN_BASE ({32'hA000_0000, 32'h8000_0000, 32'h4000_0000,
                    32'h2000_0000, 32'h0000_0000}),
        .WIN_LOG2 ({6'd12, 6'd12, 6'd12, 6'd14, 6'd16})
    ) u_mmap_guard (
        .clk(clk), .rst(rst), .htrans_i(htrans), .haddr_i(haddr),
        .hsize_i(hsize), .fetch_i(fetch), .priv_i(priv), .write_i(write),
        .slv_ready_i(slv_ready), .slv_resp_i(slv_resp),
        .hready_o(hready), .hresp_o(hresp), .fwd_sel_o(fwd_sel),
        .attr_kind_o(a_kind), .attr_xn_o(a_xn), .attr_cache_o(a_cache),
        .attr_shared_o(a_sh)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // Attribute expectation: kind, xn, cache, shared (-1 kind skips the check)
    task automatic xfer(input logic [31:0] a, input logic [2:0] sz,
                        input logic f, input logic p, input logic w,
                        input logic [1:0] tr, input logic exp_err,
                        input int ek, input logic ex, input logic [1:0] ec,
                        input logic es, input string rq);
        exp_t e;
        @(posedge clk); #1;
        haddr = a; hsize = sz; fetch = f; priv = p; write = w; htrans = tr;
        @(negedge clk);
        if (ek >= 0) begin
            chk(a_kind == ek[1:0], rq, "kind", {30'd0, a_kind}, ek);
            chk(a_xn == ex,        rq, "xn", {31'd0, a_xn}, {31'd0, ex});
            chk(a_cache == ec,     rq, "cache", {30'd0, a_cache}, {30'd0, ec});
            chk(a_sh == es,        rq, "shared", {31'd0, a_sh}, {31'd0, es});
        end
        chk(fwd_sel == (tr[1] && !exp_err), rq, "fwd_sel",
            {31'd0, fwd_sel}, {31'd0, tr[1] && !exp_err});
        e.err = exp_err;
        e.tag = rq;
        q.push_back(e);
        @(posedge clk); #1;
        htrans = 2'd0; fetch = 1'b0; write = 1'b0; priv = 1'b1;
        -> ph_ev;
        repeat (3) @(posedge clk);
    endtask

    // Monitor: pops the expected response and compares the two data-phase cycles
    initial begin
        forever begin
            exp_t e;
            @(ph_ev);
            e = q.pop_front();
            @(negedge clk);
            chk(hready == !e.err, {e.tag, " R8"}, "ready c1",
                {31'd0, hready}, {31'd0, !e.err});
            chk(hresp == e.err, {e.tag, " R8"}, "resp c1",
                {31'd0, hresp}, {31'd0, e.err});
            @(negedge clk);
            chk(hready == 1'b1, {e.tag, " R8"}, "ready c2", {31'd0, hready}, 32'd1);
            chk(hresp == e.err, {e.tag, " R8"}, "resp c2",
                {31'd0, hresp}, {31'd0, e.err});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(hready == 1'b1 && hresp == 1'b0 && fwd_sel == 1'b0, "R11", "reset outputs",
            {29'd0, hready, hresp, fwd_sel}, 32'h4);

        // R1 code / sram / ram halves
        xfer(32'h0000_0100, 3'd2, 1, 1, 0, 2'd2, 0, 0, 0, 2'd1, 0, "R1 code fetch");
        xfer(32'h2000_0010, 3'd1, 0, 1, 1, 2'd2, 0, 0, 0, 2'd2, 0, "R1 sram half");
        xfer(32'h6000_0000, 3'd0, 0, 1, 0, 2'd2, 1, 0, 0, 2'd2, 0, "R1 R7 ram low unpopulated");
        xfer(32'h8000_0004, 3'd2, 0, 1, 0, 2'd3, 0, 0, 0, 2'd1, 0, "R1 ram high seq");
        // R2 device-like regions
        xfer(32'h4000_0008, 3'd2, 0, 1, 0, 2'd2, 0, 1, 1, 2'd0, 0, "R2 periph data");
        xfer(32'hA000_0000, 3'd2, 0, 1, 1, 2'd2, 0, 1, 1, 2'd0, 1, "R2 device shared");
        xfer(32'hC000_0000, 3'd2, 0, 1, 0, 2'd2, 1, 1, 1, 2'd0, 0, "R2 R7 device nonshared");
        xfer(32'hE000_E010, 3'd2, 0, 1, 0, 2'd2, 0, 2, 1, 2'd0, 1, "R2 R5 ppb privileged");
        // R3 execute-never and fetch+write
        xfer(32'h4000_0008, 3'd2, 1, 1, 0, 2'd2, 1, 1, 1, 2'd0, 0, "R3 fetch periph");
        xfer(32'hA000_0010, 3'd2, 1, 1, 0, 2'd2, 1, -1, 0, 2'd0, 0, "R3 fetch device");
        xfer(32'h0000_0200, 3'd2, 1, 1, 1, 2'd2, 1, -1, 0, 2'd0, 0, "R3 fetch with write");
        // R4 alignment
        xfer(32'h2000_0002, 3'd2, 0, 1, 0, 2'd2, 1, -1, 0, 2'd0, 0, "R4 word at +2");
        xfer(32'h2000_0001, 3'd1, 0, 1, 0, 2'd2, 1, -1, 0, 2'd0, 0, "R4 half at +1");
        xfer(32'h2000_0002, 3'd1, 0, 1, 0, 2'd2, 0, -1, 0, 2'd0, 0, "R4 half at +2");
        xfer(32'h2000_0003, 3'd0, 0, 1, 0, 2'd2, 0, -1, 0, 2'd0, 0, "R4 byte at +3");
        xfer(32'h2000_0000, 3'd3, 0, 1, 0, 2'd2, 1, -1, 0, 2'd0, 0, "R4 size 3");
        // R5 system control page
        xfer(32'hE000_E010, 3'd2, 0, 0, 0, 2'd2, 1, -1, 0, 2'd0, 0, "R5 unpriv scs");
        xfer(32'hE000_EFFC, 3'd2, 0, 0, 1, 2'd2, 1, -1, 0, 2'd0, 0, "R5 unpriv scs top");
        xfer(32'hE000_1000, 3'd2, 0, 0, 0, 2'd2, 0, -1, 0, 2'd0, 0, "R5 unpriv ppb other");
        xfer(32'hE000_F000, 3'd2, 0, 0, 0, 2'd2, 0, -1, 0, 2'd0, 0, "R5 unpriv above scs");
        // R6 reserved range
        xfer(32'hE010_0000, 3'd2, 0, 1, 0, 2'd2, 1, 3, 1, 2'd0, 0, "R6 reserved data");
        xfer(32'hF000_0000, 3'd2, 1, 1, 0, 2'd2, 1, 3, 1, 2'd0, 0, "R6 reserved fetch");
        // R7 outside windows
        xfer(32'h0001_0000, 3'd2, 1, 1, 0, 2'd2, 1, -1, 0, 2'd0, 0, "R7 code past window");
        xfer(32'h2000_4000, 3'd2, 0, 1, 0, 2'd2, 1, -1, 0, 2'd0, 0, "R7 sram past window");
        // R9 idle and busy never err
        xfer(32'hF000_0001, 3'd3, 1, 0, 1, 2'd0, 0, -1, 0, 2'd0, 0, "R9 idle bad addr");
        xfer(32'hE000_E002, 3'd2, 1, 0, 0, 2'd1, 0, -1, 0, 2'd0, 0, "R9 busy bad addr");

        // R10 slave wait state passes through
        @(posedge clk); #1;
        haddr = 32'h2000_0020; hsize = 3'd2; htrans = 2'd2;
        @(negedge clk);
        chk(fwd_sel == 1'b1, "R10", "fwd_sel legal", {31'd0, fwd_sel}, 32'd1);
        @(posedge clk); #1;
        htrans = 2'd0; slv_ready = 1'b0;
        @(negedge clk);
        chk(hready == 1'b0 && hresp == 1'b0, "R10", "wait state",
            {30'd0, hready, hresp}, 32'd0);
        @(posedge clk); #1;
        slv_ready = 1'b1;
        @(negedge clk);
        chk(hready == 1'b1 && hresp == 1'b0, "R10", "slave done",
            {30'd0, hready, hresp}, 32'd2);

        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule